// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block picks a physical frame to give up when a page fault needs free memory. For every frame it holds two bits: a reference bit and a modified bit. The frames form a ring, and a hand points into it. The hand keeps its position from one search to the next. Every access to a frame sets that frame's reference bit, and an access that writes also sets the modified bit. When the memory manager raises a victim request, the hand sweeps the ring at one frame per clock. It clears the reference bits it finds set and stops at the first frame whose bit is already clear. That frame becomes the victim. It is reported along with its modified bit, which tells the caller whether the old contents need a writeback before the frame is reused.

A mode input selects a two-handed sweep. In that mode a leading hand runs a fixed number of frames ahead of the evicting hand and does all of the clearing. The evicting hand only tests bits and never clears them. When a new page is loaded into a frame, a fill notification marks the frame as referenced and clean.

Top module: `clock_sweeper`

## Requirements
- R1: After reset all reference and modified bits are clear, the hand is at frame 0, and `done`, `victim` and `victim_dirty` are 0. A first request therefore returns frame 0, clean.
- R2: An access notification (`acc_valid`) sets the reference bit of `acc_frame`. Read and write accesses both do this.
- R3: In single-hand mode (`two_hand`=0), each swept frame whose reference bit is set has the bit cleared and is passed over. The first frame found with a clear bit is the victim.
- R4: The hand keeps its position between requests and ends one frame past the victim, wrapping from NFRAMES-1 to 0. The next search starts there, even after idle cycles.
- R5: If every reference bit is set, a single-hand sweep clears all of them and returns the frame where the hand started. It examines NFRAMES+1 frames.
- R6: A write access (`acc_write`=1 with `acc_valid`) sets the modified bit of the frame. `victim_dirty` reports the victim's modified bit at the moment it is selected.
- R7: A fill notification (`fill_valid`) sets the reference bit of `fill_frame` and clears its modified bit.
- R8: If an access and the sweep's clearing hit the same frame in the same cycle, the access wins and the reference bit stays set.
- R9: In two-handed mode (`two_hand`=1, sampled when the request is accepted), each cycle the leading hand, GAP frames ahead, clears its frame's reference bit. The trailing hand evicts the first frame whose bit is clear and leaves set bits unchanged.
- R10: `done` is a one-cycle pulse carrying one result per accepted request. A request that arrives while a search is running is ignored.
- R11: Timing: a request accepted at clock edge 0 examines one frame on each of the following edges. If the victim is the k-th frame examined, `done` is high for the cycle after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to a frame occurred |
| acc_frame | input | FW | Frame index of the access |
| acc_write | input | 1 | The access was a write |
| fill_valid | input | 1 | A new page was installed |
| fill_frame | input | FW | Frame index of the installed page |
| two_hand | input | 1 | Selects the two-handed sweep; sampled with the request |
| req | input | 1 | Victim request |
| done | output | 1 | Result strobe, one cycle |
| victim | output | FW | Selected frame index |
| victim_dirty | output | 1 | Selected frame needs writeback |

## Verification
The bound checker looks at every cycle. After any access it requires the reference bit to be set in the next cycle, and this also covers the case where an access collides with the clearing hand. It requires a write to leave the modified bit set and a fill to leave its frame referenced and clean. Each victim must have had a clear reference bit in the cycle it was picked. The dirty flag must match the frame's modified bit, the hand must sit one past the victim, and `done` must be a single-cycle pulse. Some behaviours need a whole sequence of events before they show up at the ports, so only the bench scenarios demonstrate them: which frame a multi-step sweep lands on, how long a sweep of a fully referenced ring takes, the lead distance in two-handed mode, that the hand keeps its place between requests, and that a request raised during a search is dropped.

// File: rtl/clock_sweeper.sv
module clock_sweeper #(
  parameter int NFRAMES = 8,
  parameter int GAP = 2,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [FW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          fill_valid,
  input  logic [FW-1:0] fill_frame,
  input  logic          two_hand,
  input  logic          req,
  output logic          done,
  output logic [FW-1:0] victim,
  output logic          victim_dirty
);

  function automatic logic [FW-1:0] ring_add(input logic [FW-1:0] p, input int d);
    int s;
    s = int'(p) + d;
    if (s >= NFRAMES) s = s - NFRAMES;
    return FW'(s);
  endfunction

  logic [NFRAMES-1:0] refb, modb, ref_nx, mod_nx;
  logic [FW-1:0]      hand;
  logic               busy, mode_q;

  wire [FW-1:0] lead    = ring_add(hand, GAP);
  wire [FW-1:0] clr_idx = mode_q ? lead : hand;
  wire          hit     = !refb[hand];

  always_comb begin
    ref_nx = refb;
    mod_nx = modb;
    if (busy) ref_nx[clr_idx] = 1'b0;
    if (fill_valid) begin
      ref_nx[fill_frame] = 1'b1;
      mod_nx[fill_frame] = 1'b0;
    end
    if (acc_valid) begin
      ref_nx[acc_frame] = 1'b1;
      if (acc_write) mod_nx[acc_frame] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refb <= '0;
      modb <= '0;
      hand <= '0;
      busy <= 1'b0;
      mode_q <= 1'b0;
      done <= 1'b0;
      victim <= '0;
      victim_dirty <= 1'b0;
    end else begin
      refb <= ref_nx;
      modb <= mod_nx;
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy <= 1'b1;
          mode_q <= two_hand;
        end
      end else begin
        hand <= ring_add(hand, 1);
        if (hit) begin
          done <= 1'b1;
          victim <= hand;
          victim_dirty <= modb[hand];
          busy <= 1'b0;
        end
      end
    end
  end

endmodule

module clock_sweeper_chk #(
  parameter int NFRAMES = 8,
  parameter int FW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [FW-1:0]      acc_frame,
  input logic               acc_write,
  input logic               fill_valid,
  input logic [FW-1:0]      fill_frame,
  input logic               busy,
  input logic               done,
  input logic [FW-1:0]      victim,
  input logic               victim_dirty,
  input logic [FW-1:0]      hand,
  input logic [NFRAMES-1:0] refb,
  input logic [NFRAMES-1:0] modb
);

  wire cur_ref = refb[hand];
  wire cur_mod = modb[hand];
  wire fill_alone = fill_valid && !(acc_valid && acc_frame == fill_frame);
  wire [FW-1:0] after_victim = (int'(victim) == NFRAMES - 1) ? '0 : victim + 1'b1;

  // R2 and R8: an access leaves the bit set even when the sweep clears it in the same cycle
  assert_access_sets_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> refb[$past(acc_frame)]);

  assert_write_sets_mod_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> modb[$past(acc_frame)]);

  assert_fill_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_alone |=> refb[$past(fill_frame)] && !modb[$past(fill_frame)]);

  assert_victim_unreferenced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !$past(cur_ref));

  assert_dirty_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> victim_dirty == $past(cur_mod));

  assert_hand_past_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hand == after_victim);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind clock_sweeper clock_sweeper_chk #(.NFRAMES(NFRAMES), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
  .acc_write(acc_write), .fill_valid(fill_valid), .fill_frame(fill_frame),
  .busy(busy), .done(done), .victim(victim), .victim_dirty(victim_dirty),
  .hand(hand), .refb(refb), .modb(modb));

// File: tb/clock_sweeper_test.sv
module clock_sweeper_test;
  localparam int N = 8;
  localparam int G = 2;
  localparam int FW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, fill_valid = 1'b0, two_hand = 1'b0, req = 1'b0;
  logic [FW-1:0] acc_frame = '0, fill_frame = '0;
  logic done, victim_dirty;
  logic [FW-1:0] victim;

  always #5 clk = ~clk;

  clock_sweeper #(.NFRAMES(N), .GAP(G)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_write(acc_write), .fill_valid(fill_valid), .fill_frame(fill_frame),
    .two_hand(two_hand), .req(req), .done(done), .victim(victim),
    .victim_dirty(victim_dirty));

  typedef struct {int v; int d; int lat; string tag;} exp_t;
  exp_t sb[$];
  exp_t got;
  int total = 0, bad = 0, cyc = 0, start_cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R10: unexpected done actual victim=%0d expected no result", victim);
      end else begin
        got = sb.pop_front();
        check({got.tag, " victim"}, int'(victim), got.v);
        check({got.tag, " dirty"}, int'(victim_dirty), got.d);
        check({got.tag, " latency"}, cyc - start_cyc, got.lat);
      end
    end
  end

  task automatic push(int v, int d, int lat, string tag);
    exp_t e;
    e.v = v; e.d = d; e.lat = lat; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic ask(int v, int d, int lat, string tag);
    @(negedge clk);
    req = 1'b1;
    start_cyc = cyc;
    push(v, d, lat, tag);
    @(negedge clk);
    req = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic touch(int f, bit w);
    @(negedge clk);
    acc_valid = 1'b1; acc_frame = FW'(f); acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic fill(int f);
    @(negedge clk);
    fill_valid = 1'b1; fill_frame = FW'(f);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset victim", int'(victim), 0);
    check("R1 reset dirty", int'(victim_dirty), 0);
    rst_n = 1'b1;

    ask(0, 0, 2, "R1 first request");
    touch(1, 0); touch(2, 0);
    ask(3, 0, 4, "R3 skip referenced");
    touch(4, 0); touch(5, 1);
    ask(6, 0, 4, "R4 hand persists");
    for (int f = 0; f < 7; f++) touch(f, 0);
    touch(7, 1);
    ask(7, 1, 10, "R5 R6 all referenced dirty start");
    touch(0, 1); fill(0);
    for (int f = 1; f < 8; f++) touch(f, 0);
    ask(0, 0, 10, "R7 fill cleans frame");
    fill(1);
    ask(2, 0, 3, "R7 fill references frame");

    touch(3, 0);
    @(negedge clk);
    req = 1'b1; start_cyc = cyc; push(4, 0, 3, "R8 collision step");
    @(negedge clk);
    req = 1'b0; acc_valid = 1'b1; acc_frame = 3'd3;
    @(negedge clk);
    acc_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    for (int f = 0; f < 8; f++) if (f != 3) touch(f, 0);
    ask(5, 1, 10, "R8 access kept bit");

    touch(6, 0); touch(7, 0); touch(0, 0); touch(1, 0);
    @(negedge clk);
    req = 1'b1; start_cyc = cyc; push(2, 0, 6, "R10 R11 busy request");
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    ask(3, 0, 2, "R10 dropped request left no trace");

    for (int f = 0; f < 8; f++) touch(f, 0);
    two_hand = 1'b1;
    ask(6, 0, 4, "R9 lead hand clears");
    ask(7, 1, 2, "R9 second two-hand");
    two_hand = 1'b0;
    repeat (20) @(negedge clk);
    ask(0, 0, 2, "R4 after idle");
    ask(1, 0, 2, "R4 next frame");
    ask(6, 0, 6, "R9 trailing hand left bits set");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule